// File: doc/BRIEF.md
# Stream Pipeline Stage Shell

This block wraps one processing function inside a multi-stream pipeline. Each cycle a chunk's control arrives: stream id, chunk id, a 2-bit kind, an end marker and a flush marker. That chunk's 64-bit payload arrives one cycle later. The shell registers the control and re-times the payload, so the one-cycle offset between control and data is the same on its outputs as on its inputs.

The kind field selects how the rest of the chunk is read. For setup chunks and memory requests, the chunk id and stream id are joined into one address that names a target module and carries a user bit. Setup chunks addressed to this shell load a small register file in two steps: first an address word, then a data word. The register file sets which stream the shell owns and the constant its function uses.

Payload chunks of the owned stream pass through unchanged. In addition, each one yields a result (payload plus a configured addend). The result is queued and later written into a free slot of the stream. A flush on the owned stream throws away every pending result.

Top module: `stream_stage_shell`

## Requirements
- R1: Each output control field appears one cycle after the matching input control, and output data appears one cycle after that output control, which is two cycles after the input control. A chunk that no other rule touches leaves with every field unchanged, and this includes payload chunks of the owned stream.
- R2: While reset is high and in the cycle after it, the outputs are all zero (kind 0, markers low). Reset clears the register file and the pending register index, so no stream is owned until setup writes one.
- R3: The kind codes are 0 idle, 1 payload, 2 setup and 3 memory request. For kinds 2 and 3 the address is {chunk id, stream id}: bits [2:0] give the module id and bit 3 (stream id bit 3) is the user bit. A setup chunk for MODULE_ID with the user bit set stores data bit 0 as the pending register index. With the user bit clear, it writes the whole data word to the register at the pending index, and that index stays in place for later data words. A consumed setup chunk leaves as kind 0, with its stream id, chunk id and markers unchanged.
- R4: A setup chunk addressed to any other module id passes through unchanged.
- R5: A memory request passes through unchanged, even when its module id equals MODULE_ID.
- R6: Register 0 holds the ownership setting: bit 4 is the enable and bits [3:0] are the owned stream id. Register 1 holds the addend. The result of an owned payload is payload + addend, modulo 2^64.
- R7: A result whose source control arrived in cycle t is written into the first free chunk whose control arrives in cycle t+2 or later. That chunk may belong to any stream. It leaves as kind 1 with the owned stream id, the source chunk id, both markers low, and the result as its data.
- R8: A chunk is free only when its kind is 0 and both markers are low. An idle chunk with end or flush high is never overwritten and passes through unchanged.
- R9: Pending results are kept in arrival order, at most FIFO_DEPTH (4) of them. A result produced while all entries are in use is discarded.
- R10: A flush chunk on the owned stream discards every pending result, and its own payload yields no result. A flush on another stream, or an end marker, has no effect on pending results.
- R11: Chunk ids are not assumed to be unique or ordered. Several payloads with the same chunk id each yield their own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_sid | input | 4 | Input stream id |
| in_cid | input | 4 | Input chunk id |
| in_kind | input | 2 | Input chunk kind |
| in_last | input | 1 | Input end-of-stream marker |
| in_abort | input | 1 | Input flush marker |
| in_data | input | 64 | Input payload, one cycle after its control |
| out_sid | output | 4 | Output stream id |
| out_cid | output | 4 | Output chunk id |
| out_kind | output | 2 | Output chunk kind |
| out_last | output | 1 | Output end-of-stream marker |
| out_abort | output | 1 | Output flush marker |
| out_data | output | 64 | Output payload, one cycle after its control |

## Verification
The bench sweeps a payload over all sixteen stream ids and checks that only the owned one produces a result. A shell that decoded the stream id wrongly would insert results for the wrong streams or for none. Directed cases check the timing edge: the free slot one cycle after a payload must stay free, and an idle chunk carrying a marker must never be reused. A shell that got either wrong would lose an empty-stream end or flush, or misplace data against control. Further sequences fill the result queue past its depth with repeated chunk ids and then flush it, so a shell that reordered, overflowed or kept stale results gives wrong slot contents. Setup cases cover other modules' ids, memory requests aimed at this module and a pending index reused across several data words; a wrong address split would pass or consume the wrong chunks.

// File: rtl/sps_pkg.sv
package sps_pkg;

    parameter int SID_W  = 4;
    parameter int CID_W  = 4;
    parameter int MID_W  = 3;
    parameter int DATA_W = 64;
    parameter int NREG   = 2;

    localparam int ADDR_W     = SID_W + CID_W;
    localparam int RIDX_W     = (NREG > 1) ? $clog2(NREG) : 1;
    localparam int USER_POS   = MID_W;
    localparam int OWN_EN_POS = SID_W;
    localparam int REG_OWNER  = 0;
    localparam int REG_ADDEND = 1;

    typedef enum logic [1:0] {
        KIND_IDLE    = 2'd0,
        KIND_PAYLOAD = 2'd1,
        KIND_SETUP   = 2'd2,
        KIND_MEMREQ  = 2'd3
    } kind_e;

    typedef struct packed {
        logic [SID_W-1:0] sid;
        logic [CID_W-1:0] cid;
        kind_e            kind;
        logic             last;
        logic             abort;
    } ctrl_t;

    typedef struct packed {
        logic [CID_W-1:0]  cid;
        logic [DATA_W-1:0] val;
    } res_t;

    function automatic logic is_free(ctrl_t c);
        return (c.kind == KIND_IDLE) && !c.last && !c.abort;
    endfunction

    function automatic logic [MID_W-1:0] target_mod(ctrl_t c);
        logic [ADDR_W-1:0] a;
        a = {c.cid, c.sid};
        return a[MID_W-1:0];
    endfunction

    function automatic logic user_bit(ctrl_t c);
        logic [ADDR_W-1:0] a;
        a = {c.cid, c.sid};
        return a[USER_POS];
    endfunction

endpackage

// File: rtl/sps_setup_regs.sv
module sps_setup_regs
    import sps_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_index,
    input  logic              wr_value,
    input  logic [DATA_W-1:0] din,
    output logic              own_en,
    output logic [SID_W-1:0]  own_sid,
    output logic [DATA_W-1:0] addend
);

    logic [DATA_W-1:0] regs_q [NREG];
    logic [RIDX_W-1:0] pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else begin
            if (wr_index) pend_q <= din[RIDX_W-1:0];
            if (wr_value) regs_q[pend_q] <= din;
        end
    end

    assign own_en  = regs_q[REG_OWNER][OWN_EN_POS];
    assign own_sid = regs_q[REG_OWNER][SID_W-1:0];
    assign addend  = regs_q[REG_ADDEND];

    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_index |=> $stable(pend_q)); // R3

endmodule

// File: rtl/sps_result_fifo.sv
module sps_result_fifo
    import sps_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic push,
    input  res_t din,
    input  logic pop,
    output res_t dout,
    output logic empty
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    res_t             mem_q [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] cnt_q;
    logic             full, do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign dout    = mem_q[rd_q];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= bump(wr_q);
            if (do_pop)  rd_q <= bump(rd_q);
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[wr_q] <= din;
    end

    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        clr |=> empty); // R10
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (push && !full && !pop && !clr) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R9
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        full |=> (cnt_q <= CNT_W'(DEPTH))); // R9

endmodule

// File: rtl/stream_stage_shell.sv
module stream_stage_shell
    import sps_pkg::*;
#(
    parameter logic [MID_W-1:0] MODULE_ID  = 3'd5,
    parameter int               FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SID_W-1:0]  in_sid,
    input  logic [CID_W-1:0]  in_cid,
    input  logic [1:0]        in_kind,
    input  logic              in_last,
    input  logic              in_abort,
    input  logic [DATA_W-1:0] in_data,
    output logic [SID_W-1:0]  out_sid,
    output logic [CID_W-1:0]  out_cid,
    output logic [1:0]        out_kind,
    output logic              out_last,
    output logic              out_abort,
    output logic [DATA_W-1:0] out_data
);

    ctrl_t             cin, prev_q, out_q, nxt_out;
    logic              prev_owned_q, prev_mine_q;
    logic              ins_q;
    logic [DATA_W-1:0] ins_val_q, data_q;

    logic              own_en;
    logic [SID_W-1:0]  own_sid;
    logic [DATA_W-1:0] addend;

    logic owns, flush_own, setup_mine, take;
    logic fifo_push, fifo_empty;
    res_t fifo_in, fifo_out;

    assign cin = '{sid: in_sid, cid: in_cid, kind: kind_e'(in_kind),
                   last: in_last, abort: in_abort};

    assign owns       = own_en && (cin.sid == own_sid);
    assign flush_own  = owns && cin.abort;
    assign setup_mine = (cin.kind == KIND_SETUP) && (target_mod(cin) == MODULE_ID);
    assign take       = is_free(cin) && !fifo_empty;

    // payload of the chunk registered last cycle is on in_data now
    assign fifo_push = (prev_q.kind == KIND_PAYLOAD) && prev_owned_q
                       && !prev_q.abort && !flush_own;
    assign fifo_in   = '{cid: prev_q.cid, val: in_data + addend};

    sps_setup_regs i_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_index (prev_mine_q && user_bit(prev_q)),
        .wr_value (prev_mine_q && !user_bit(prev_q)),
        .din      (in_data),
        .own_en   (own_en),
        .own_sid  (own_sid),
        .addend   (addend)
    );

    sps_result_fifo #(.DEPTH(FIFO_DEPTH)) i_fifo (
        .clk   (clk),
        .rst   (rst),
        .clr   (flush_own),
        .push  (fifo_push),
        .din   (fifo_in),
        .pop   (take),
        .dout  (fifo_out),
        .empty (fifo_empty)
    );

    always_comb begin
        nxt_out = cin;
        if (take) begin
            nxt_out = '{sid: own_sid, cid: fifo_out.cid, kind: KIND_PAYLOAD,
                        last: 1'b0, abort: 1'b0};
        end else if (setup_mine) begin
            nxt_out.kind = KIND_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q       <= '0;
            prev_owned_q <= 1'b0;
            prev_mine_q  <= 1'b0;
            out_q        <= '0;
            ins_q        <= 1'b0;
            ins_val_q    <= '0;
            data_q       <= '0;
        end else begin
            prev_q       <= cin;
            prev_owned_q <= owns;
            prev_mine_q  <= setup_mine;
            out_q        <= nxt_out;
            ins_q        <= take;
            ins_val_q    <= fifo_out.val;
            data_q       <= ins_q ? ins_val_q : in_data;
        end
    end

    assign out_sid   = out_q.sid;
    assign out_cid   = out_q.cid;
    assign out_kind  = out_q.kind;
    assign out_last  = out_q.last;
    assign out_abort = out_q.abort;
    assign out_data  = data_q;

    AST_MEM_PASS: assert property (@(posedge clk) disable iff (rst)
        (in_kind == 2'd3) |=> (out_kind == 2'd3 && out_sid == $past(in_sid)
                               && out_cid == $past(in_cid))); // R5
    AST_SETUP_OTHER: assert property (@(posedge clk) disable iff (rst)
        (cin.kind == KIND_SETUP && target_mod(cin) != MODULE_ID)
        |=> (out_kind == 2'd2 && out_sid == $past(in_sid))); // R4
    AST_MARKED_KEPT: assert property (@(posedge clk) disable iff (rst)
        (in_kind == 2'd0 && (in_last || in_abort))
        |=> (out_kind == 2'd0 && out_last == $past(in_last)
             && out_abort == $past(in_abort))); // R8
    AST_FREE_ONLY: assert property (@(posedge clk) disable iff (rst)
        (out_kind == 2'd1 && $past(in_kind) == 2'd0)
        |-> ($past(!in_last) && $past(!in_abort))); // R7

endmodule

// File: tb/test_stream_stage_shell.sv
module test_stream_stage_shell;

    localparam logic [63:0] K1 = 64'h0000_0001_0000_0033;
    localparam logic [63:0] K2 = 64'hFFFF_FFFF_FFFF_FFF0;
    localparam logic [3:0]  OWN = 4'd6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [3:0]  in_sid = '0, in_cid = '0;
    logic [1:0]  in_kind = '0;
    logic        in_last = 1'b0, in_abort = 1'b0;
    logic [63:0] in_data = '0;
    logic [3:0]  out_sid, out_cid;
    logic [1:0]  out_kind;
    logic        out_last, out_abort;
    logic [63:0] out_data;

    stream_stage_shell i_stream_stage_shell (
        .clk(clk), .rst(rst),
        .in_sid(in_sid), .in_cid(in_cid), .in_kind(in_kind),
        .in_last(in_last), .in_abort(in_abort), .in_data(in_data),
        .out_sid(out_sid), .out_cid(out_cid), .out_kind(out_kind),
        .out_last(out_last), .out_abort(out_abort), .out_data(out_data)
    );

    int total = 0, bad = 0, st = 0;
    bit done = 0;
    logic [11:0] lctl [0:1023];
    logic [63:0] ldat [0:1023];
    logic [63:0] pend = '0;

    task automatic step(input logic [3:0] s, input logic [3:0] c, input logic [1:0] k,
                        input logic l, input logic a, input logic [63:0] d, output int idx);
        @(negedge clk);
        lctl[st] = {out_sid, out_cid, out_kind, out_last, out_abort};
        ldat[st] = out_data;
        in_data = pend;
        in_sid = s; in_cid = c; in_kind = k; in_last = l; in_abort = a;
        pend = d;
        idx = st;
        st++;
    endtask

    task automatic idle(input int n);
        int x;
        for (int i = 0; i < n; i++) step(4'd9, 4'd0, 2'd0, 1'b0, 1'b0, 64'd0, x);
    endtask

    task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic chk_ctl(input string r, input int i, input logic [3:0] s, input logic [3:0] c,
                           input logic [1:0] k, input logic l, input logic a);
        chk(r, {52'd0, lctl[i+1]}, {52'd0, s, c, k, l, a});
    endtask

    task automatic chk_dat(input string r, input int i, input logic [63:0] d);
        chk(r, ldat[i+2], d);
    endtask

    function automatic logic [63:0] pat(input int n);
        return 64'h0123_4567_89AB_CDEF * 64'(n + 3) + 64'd77;
    endfunction

    initial begin
        #(20 * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int a0, a1, a2, b0, b1, c0, d0, d1, p, f1, f2, f3, g, h, j;
        logic [63:0] gd [5];
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R2: outputs zero during reset
        chk("R2", {50'd0, out_sid, out_cid, out_kind, out_last, out_abort}, 64'd0);
        chk("R2", out_data, 64'd0);
        rst = 1'b0;

        // R2: register file cleared, stream 6 not owned yet
        step(OWN, 4'd1, 2'd1, 0, 0, 64'h55, a0);
        step(4'd9, 4'd0, 2'd0, 0, 0, 64'd0, a1);
        step(4'd9, 4'd0, 2'd0, 0, 0, 64'd0, a2);
        idle(3);
        chk_ctl("R2", a0, OWN, 4'd1, 2'd1, 0, 0);
        chk_dat("R1", a0, 64'h55);
        chk_ctl("R2", a2, 4'd9, 4'd0, 2'd0, 0, 0);

        // R4: setup aimed at module 2 passes unchanged
        step(4'hA, 4'd3, 2'd2, 0, 0, 64'hAB, b0);
        step(4'h2, 4'd3, 2'd2, 0, 0, 64'hCD, b1);
        // R5: memory request aimed at own module 5 passes unchanged
        step(4'h5, 4'd7, 2'd3, 0, 0, 64'hEF, c0);
        idle(3);
        chk_ctl("R4", b0, 4'hA, 4'd3, 2'd2, 0, 0);
        chk_dat("R4", b0, 64'hAB);
        chk_ctl("R4", b1, 4'h2, 4'd3, 2'd2, 0, 0);
        chk_ctl("R5", c0, 4'h5, 4'd7, 2'd3, 0, 0);
        chk_dat("R5", c0, 64'hEF);

        // R3: configure: index word (user bit = sid[3]) then value word
        step(4'hD, 4'd2, 2'd2, 0, 0, 64'd1, d0);
        step(4'h5, 4'd0, 2'd2, 0, 0, 64'd999, d1);
        step(4'h5, 4'd0, 2'd2, 0, 0, K1, j);       // same pending index, overwrites
        step(4'hD, 4'd0, 2'd2, 0, 0, 64'd0, j);
        step(4'h5, 4'd4, 2'd2, 0, 0, {59'd0, 1'b1, OWN}, j);
        idle(3);
        chk_ctl("R3", d0, 4'hD, 4'd2, 2'd0, 0, 0);
        chk_ctl("R3", d1, 4'h5, 4'd0, 2'd0, 0, 0);

        // R6 R7 R1: sweep payload over all streams
        for (int s = 0; s < 16; s++) begin
            step(4'(s), 4'(s), 2'd1, 0, 0, pat(s), p);
            step(4'd9, 4'd0, 2'd0, 0, 0, 64'd0, f1);
            step(4'd9, 4'd0, 2'd0, 0, 0, 64'd0, f2);
            step(4'd9, 4'd0, 2'd0, 0, 0, 64'd0, f3);
            idle(2);
            chk_ctl("R1", p, 4'(s), 4'(s), 2'd1, 0, 0);
            chk_dat("R1", p, pat(s));
            chk_ctl("R7", f1, 4'd9, 4'd0, 2'd0, 0, 0);
            if (s == 6) begin
                chk_ctl("R7", f2, OWN, 4'(s), 2'd1, 0, 0);
                chk_dat("R6", f2, pat(s) + K1);
            end else begin
                chk_ctl("R7", f2, 4'd9, 4'd0, 2'd0, 0, 0);
            end
            chk_ctl("R7", f3, 4'd9, 4'd0, 2'd0, 0, 0);
        end

        // R8 R10: marked idle chunks kept; end and foreign flush do not clear
        step(OWN, 4'd1, 2'd1, 0, 0, pat(40), p);
        step(OWN, 4'd0, 2'd0, 1, 0, 64'd0, f1);
        step(4'd3, 4'd0, 2'd0, 0, 1, 64'd0, f2);
        step(4'd9, 4'd0, 2'd0, 0, 0, 64'd0, f3);
        idle(3);
        chk_ctl("R8", f1, OWN, 4'd0, 2'd0, 1, 0);
        chk_ctl("R8", f2, 4'd3, 4'd0, 2'd0, 0, 1);
        chk_ctl("R10", f3, OWN, 4'd1, 2'd1, 0, 0);
        chk_dat("R10", f3, pat(40) + K1);

        // R9 R11: five results with one chunk id, depth four
        for (int i = 0; i < 5; i++) begin
            gd[i] = pat(50 + i);
            step(OWN, 4'd3, 2'd1, 0, 0, gd[i], p);
            if (i == 0) g = p;
        end
        step(4'h1, 4'd1, 2'd3, 0, 0, 64'h1234, p);
        idle(7);
        for (int i = 0; i < 4; i++) begin
            chk_ctl("R11", g + 6 + i, OWN, 4'd3, 2'd1, 0, 0);
            chk_dat("R9", g + 6 + i, gd[i] + K1);
        end
        chk_ctl("R9", g + 10, 4'd9, 4'd0, 2'd0, 0, 0);

        // R10: owned flush discards pending results
        step(OWN, 4'd2, 2'd1, 0, 0, pat(60), h);
        step(OWN, 4'd2, 2'd1, 0, 0, pat(61), p);
        step(4'h1, 4'd1, 2'd3, 0, 0, 64'd0, p);
        step(OWN, 4'd0, 2'd0, 0, 1, 64'd0, p);
        idle(3);
        chk_ctl("R8", h + 3, OWN, 4'd0, 2'd0, 0, 1);
        chk_ctl("R10", h + 4, 4'd9, 4'd0, 2'd0, 0, 0);
        chk_ctl("R10", h + 5, 4'd9, 4'd0, 2'd0, 0, 0);
        // R10: flushing payload yields no result
        step(OWN, 4'd5, 2'd1, 0, 1, pat(62), p);
        step(4'h1, 4'd1, 2'd3, 0, 0, 64'd0, f1);
        idle(4);
        chk_ctl("R10", p, OWN, 4'd5, 2'd1, 0, 1);
        chk_ctl("R10", f1 + 1, 4'd9, 4'd0, 2'd0, 0, 0);
        chk_ctl("R10", f1 + 2, 4'd9, 4'd0, 2'd0, 0, 0);

        // R6: new addend, wrap modulo 2^64, queue usable after flush
        step(4'hD, 4'd0, 2'd2, 0, 0, 64'd1, j);
        step(4'h5, 4'd0, 2'd2, 0, 0, K2, j);
        idle(2);
        step(OWN, 4'd7, 2'd1, 0, 0, 64'h100, p);
        idle(4);
        chk_ctl("R7", p + 2, OWN, 4'd7, 2'd1, 0, 0);
        chk_dat("R6", p + 2, 64'h100 + K2);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule